// File: doc/BRIEF.md
# 8-bit Arithmetic-Logic Unit with Status Flags

This block is the combinational arithmetic-logic unit of a small accumulator-style processor core. It takes two 8-bit operands and an incoming carry. The working register drives operand A, and a file or literal value drives operand B. A 4-bit operation code selects among thirteen functions: add, subtract, three bitwise logic operations, complement, increment, decrement, rotate left or right through the carry, nibble swap, clear and pass-through. The block returns the 8-bit result, values for the zero, digit-carry and carry flags, and one update enable for each flag.

Subtraction adds the two's complement of the subtrahend. The carry and digit-carry flags therefore read as an inverted borrow: a set flag means no borrow occurred. The digit carry is the carry from bit 3 into bit 4. An operation raises only the update enables of the flags it defines. The surrounding core writes a flag only when its enable is high, so every other flag keeps its stored value. Writing back the result and decoding instructions belong to the surrounding core.

The datapath has three units and one decoder. A single adder with a split at the nibble boundary serves add, subtract, increment and decrement. A bitwise unit serves the logic operations and complement. A rotate unit serves the two rotates and the nibble swap. The decoder chooses the adder operands and the result source, and it raises the flag update enables.

Top module: `alu8_core`

## Requirements
- R1: With op_sel = 0 (add), result is (A + B) mod 256, flag_c is the carry out of bit 7, flag_dc is the carry out of bit 3, and all three update enables are high.
- R2: With op_sel = 1 (subtract), result is (B − A) mod 256, flag_c = 1 exactly when B ≥ A (no borrow), flag_dc = 1 exactly when B[3:0] ≥ A[3:0], and all three update enables are high; for B = 0x00 and A = 0x01 the result is 0xFF with flag_c = 0 and flag_dc = 0.
- R3: Whenever upd_z is high, flag_z is 1 exactly when the 8-bit result is zero.
- R4: op_sel = 2 gives A AND B, 3 gives A OR B, 4 gives A XOR B, and 5 gives the complement of B; these raise upd_z only.
- R5: op_sel = 6 gives B + 1 and op_sel = 7 gives B − 1, both modulo 256. Both raise upd_z only, and carry_in does not affect the result.
- R6: op_sel = 8 (rotate left) gives {B[6:0], carry_in} with flag_c = B[7]. op_sel = 9 (rotate right) gives {carry_in, B[7:1]} with flag_c = B[0]. Both raise upd_c only.
- R7: op_sel = 10 returns B with its two nibbles exchanged and raises no update enable.
- R8: op_sel = 11 returns 0 with flag_z = 1, and op_sel = 12 returns B. Both raise upd_z only.
- R9: A flag output whose update enable is low is driven 0. Codes 13 to 15 return 0 and raise no update enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_w | input | 8 | Operand A, from the working register |
| opnd_f | input | 8 | Operand B, a file register or literal |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Current carry flag, used by the rotates |
| result | output | 8 | Operation result |
| flag_z | output | 1 | Zero flag value |
| flag_dc | output | 1 | Digit carry / inverted nibble borrow value |
| flag_c | output | 1 | Carry / inverted borrow value |
| upd_z | output | 1 | Zero flag update enable |
| upd_dc | output | 1 | Digit carry update enable |
| upd_c | output | 1 | Carry update enable |

## Verification
The zero detector and the carry chain can report events from the same operation. A sum that wraps to exactly zero, or a subtraction of equal operands, must raise zero and carry together, and sometimes the digit carry as well. Exhaustive add and subtract sweeps cover every such pair. Directed vectors such as 0x80 + 0x80, 0x0F + 0xF1 and 0x5A − 0x5A pin these cases down. Each observed flag set is compared against values the bench computes from plain 9-bit and 5-bit arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_IOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_COM  = 4'd5,
        OP_INC  = 4'd6,
        OP_DEC  = 4'd7,
        OP_RLC  = 4'd8,
        OP_RRC  = 4'd9,
        OP_SWAP = 4'd10,
        OP_CLR  = 4'd11,
        OP_PASS = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        SRC_ADDER = 3'd0,
        SRC_LOGIC = 3'd1,
        SRC_ROT   = 3'd2,
        SRC_PASS  = 3'd3,
        SRC_ZERO  = 3'd4
    } res_src_e;

    typedef enum logic [1:0] {
        ADD_A_PLUS_B  = 2'd0,
        ADD_B_MINUS_A = 2'd1,
        ADD_B_PLUS_1  = 2'd2,
        ADD_B_MINUS_1 = 2'd3
    } add_mode_e;

    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } flag_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  logic [OP_BITS-1:0] op_sel,
    output res_src_e           src,
    output add_mode_e          add_mode,
    output flag_t              upd
);

    alu_op_e op;
    assign op = alu_op_e'(op_sel);

    always_comb begin
        src      = SRC_ZERO;
        add_mode = ADD_A_PLUS_B;
        upd      = '0;
        case (op)
            OP_ADD: begin
                src      = SRC_ADDER;
                add_mode = ADD_A_PLUS_B;
                upd      = '{z: 1'b1, dc: 1'b1, c: 1'b1};
            end
            OP_SUB: begin
                src      = SRC_ADDER;
                add_mode = ADD_B_MINUS_A;
                upd      = '{z: 1'b1, dc: 1'b1, c: 1'b1};
            end
            OP_INC: begin
                src      = SRC_ADDER;
                add_mode = ADD_B_PLUS_1;
                upd.z    = 1'b1;
            end
            OP_DEC: begin
                src      = SRC_ADDER;
                add_mode = ADD_B_MINUS_1;
                upd.z    = 1'b1;
            end
            OP_AND, OP_IOR, OP_XOR, OP_COM: begin
                src   = SRC_LOGIC;
                upd.z = 1'b1;
            end
            OP_RLC, OP_RRC: begin
                src   = SRC_ROT;
                upd.c = 1'b1;
            end
            OP_SWAP: begin
                src = SRC_ROT;
            end
            OP_CLR: begin
                src   = SRC_ZERO;
                upd.z = 1'b1;
            end
            OP_PASS: begin
                src   = SRC_PASS;
                upd.z = 1'b1;
            end
            default: begin
                src = SRC_ZERO;
                upd = '0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH  = 8,
    parameter int NIBBLE = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             nib_co,
    output logic             co
);

    localparam int HI_W = WIDTH - NIBBLE;

    logic [NIBBLE:0] lo_part;
    logic [HI_W:0]   hi_part;

    always_comb begin
        lo_part = {1'b0, x[NIBBLE-1:0]} + {1'b0, y[NIBBLE-1:0]}
                + {{NIBBLE{1'b0}}, cin};
        hi_part = {1'b0, x[WIDTH-1:NIBBLE]} + {1'b0, y[WIDTH-1:NIBBLE]}
                + {{HI_W{1'b0}}, lo_part[NIBBLE]};
    end

    assign sum    = {hi_part[HI_W-1:0], lo_part[NIBBLE-1:0]};
    assign nib_co = lo_part[NIBBLE];
    assign co     = hi_part[HI_W];

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_BITS-1:0] op_sel,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);

    always_comb begin
        case (alu_op_e'(op_sel))
            OP_AND:  y = a & b;
            OP_IOR:  y = a | b;
            OP_XOR:  y = a ^ b;
            OP_COM:  y = ~b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [OP_BITS-1:0] op_sel,
    input  logic [WIDTH-1:0]   b,
    input  logic               cin,
    output logic [WIDTH-1:0]   y,
    output logic               co
);

    localparam int HALF = WIDTH / 2;

    logic [WIDTH-1:0] swapped;

    genvar gi;
    generate
        for (gi = 0; gi < HALF; gi++) begin : g_swap
            assign swapped[gi]        = b[gi + HALF];
            assign swapped[gi + HALF] = b[gi];
        end
    endgenerate

    always_comb begin
        case (alu_op_e'(op_sel))
            OP_RLC: begin
                y  = {b[WIDTH-2:0], cin};
                co = b[WIDTH-1];
            end
            OP_RRC: begin
                y  = {cin, b[WIDTH-1:1]};
                co = b[0];
            end
            OP_SWAP: begin
                y  = swapped;
                co = 1'b0;
            end
            default: begin
                y  = '0;
                co = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int NIBBLE = 4
) (
    input  logic [WIDTH-1:0]   opnd_w,
    input  logic [WIDTH-1:0]   opnd_f,
    input  logic [OP_BITS-1:0] op_sel,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   result,
    output logic               flag_z,
    output logic               flag_dc,
    output logic               flag_c,
    output logic               upd_z,
    output logic               upd_dc,
    output logic               upd_c
);

    res_src_e         src;
    add_mode_e        add_mode;
    flag_t            upd;
    logic [WIDTH-1:0] add_x;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_nib_co;
    logic             add_co;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] rot_y;
    logic             rot_co;
    logic             res_zero;

    alu8_decode u_dec (
        .op_sel   (op_sel),
        .src      (src),
        .add_mode (add_mode),
        .upd      (upd)
    );

    always_comb begin
        case (add_mode)
            ADD_A_PLUS_B: begin
                add_x   = opnd_w;
                add_cin = 1'b0;
            end
            ADD_B_MINUS_A: begin
                add_x   = ~opnd_w;
                add_cin = 1'b1;
            end
            ADD_B_PLUS_1: begin
                add_x   = '0;
                add_cin = 1'b1;
            end
            default: begin
                add_x   = '1;
                add_cin = 1'b0;
            end
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH), .NIBBLE(NIBBLE)) u_add (
        .x      (add_x),
        .y      (opnd_f),
        .cin    (add_cin),
        .sum    (add_sum),
        .nib_co (add_nib_co),
        .co     (add_co)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bit (
        .op_sel (op_sel),
        .a      (opnd_w),
        .b      (opnd_f),
        .y      (logic_y)
    );

    alu8_rotate #(.WIDTH(WIDTH)) u_rot (
        .op_sel (op_sel),
        .b      (opnd_f),
        .cin    (carry_in),
        .y      (rot_y),
        .co     (rot_co)
    );

    always_comb begin
        case (src)
            SRC_ADDER: result = add_sum;
            SRC_LOGIC: result = logic_y;
            SRC_ROT:   result = rot_y;
            SRC_PASS:  result = opnd_f;
            default:   result = '0;
        endcase
    end

    assign res_zero = ~|result;

    assign flag_z  = upd.z  & res_zero;
    assign flag_dc = upd.dc & add_nib_co;
    assign flag_c  = upd.c  & ((src == SRC_ROT) ? rot_co : add_co);
    assign upd_z   = upd.z;
    assign upd_dc  = upd.dc;
    assign upd_c   = upd.c;

endmodule

// File: rtl/alu8_checker.sv
module alu8_checker
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0]   opnd_w,
    input logic [WIDTH-1:0]   opnd_f,
    input logic [OP_BITS-1:0] op_sel,
    input logic               carry_in,
    input logic [WIDTH-1:0]   result,
    input logic               flag_z,
    input logic               flag_dc,
    input logic               flag_c,
    input logic               upd_z,
    input logic               upd_dc,
    input logic               upd_c
);

    logic known;
    assign known = !$isunknown({opnd_w, opnd_f, op_sel, carry_in, result,
                                flag_z, flag_dc, flag_c, upd_z, upd_dc, upd_c});

    always_comb begin
        if (known) begin
            if (op_sel == OP_ADD) begin
                p_add_sum_r1: assert ({flag_c, result} ==
                                      ({1'b0, opnd_w} + {1'b0, opnd_f}))
                    else $error("add sum/carry mismatch");
            end
            if (op_sel == OP_SUB) begin
                p_sub_inverse_r2: assert (WIDTH'(result + opnd_w) == opnd_f
                                          && flag_c == (opnd_f >= opnd_w))
                    else $error("subtract result/borrow mismatch");
            end
            if (upd_z) begin
                p_zero_flag_r3: assert (flag_z == ($countones(result) == 0))
                    else $error("zero flag mismatch");
            end
            if (op_sel == OP_RLC) begin
                p_rotl_r6: assert (result[0] == carry_in && flag_c == opnd_f[WIDTH-1]
                                   && upd_c && !upd_z && !upd_dc)
                    else $error("rotate left mismatch");
            end
            if (op_sel == OP_SWAP) begin
                p_swap_noflag_r7: assert (!upd_z && !upd_dc && !upd_c
                                          && $countones(result) == $countones(opnd_f))
                    else $error("swap mismatch");
            end
            p_masked_flags_r9: assert ((upd_z || !flag_z) && (upd_dc || !flag_dc)
                                       && (upd_c || !flag_c))
                else $error("flag driven without enable");
        end
    end

endmodule

bind alu8_core alu8_checker #(.WIDTH(WIDTH)) u_alu8_checker (
    .opnd_w   (opnd_w),
    .opnd_f   (opnd_f),
    .op_sel   (op_sel),
    .carry_in (carry_in),
    .result   (result),
    .flag_z   (flag_z),
    .flag_dc  (flag_dc),
    .flag_c   (flag_c),
    .upd_z    (upd_z),
    .upd_dc   (upd_dc),
    .upd_c    (upd_c)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opnd_w = '0;
    logic [7:0] opnd_f = '0;
    logic [3:0] op_sel = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       flag_z, flag_dc, flag_c, upd_z, upd_dc, upd_c;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    alu8_core dut (
        .opnd_w   (opnd_w),
        .opnd_f   (opnd_f),
        .op_sel   (op_sel),
        .carry_in (carry_in),
        .result   (result),
        .flag_z   (flag_z),
        .flag_dc  (flag_dc),
        .flag_c   (flag_c),
        .upd_z    (upd_z),
        .upd_dc   (upd_dc),
        .upd_c    (upd_c)
    );

    function automatic logic [13:0] mk(input logic [7:0] r, input logic z, dc, c,
                                       input logic uz, udc, uc);
        return {r, z, dc, c, uz, udc, uc};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [7:0] a, b, input logic ci);
        @(negedge clk);
        op_sel   = op;
        opnd_w   = a;
        opnd_f   = b;
        carry_in = ci;
        #1;
    endtask

    task automatic check(input string req, input logic [13:0] exp);
        logic [13:0] got;
        got = {result, flag_z, flag_dc, flag_c, upd_z, upd_dc, upd_c};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h ci=%b: got %h exp %h",
                     req, op_sel, opnd_w, opnd_f, carry_in, got, exp);
        end
    endtask

    task automatic t_reset();
        // Idle inputs (add of zeros): zero result, zero flag, all enables
        check("R1 idle", mk(8'h00, 1, 0, 0, 1, 1, 1));
    endtask

    task automatic t_add_sweep();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [8:0] s;
                logic [4:0] n;
                s = 9'(a) + 9'(b);
                n = 5'(a[3:0]) + 5'(b[3:0]);
                apply(4'd0, 8'(a), 8'(b), 1'(b & 1));
                check("R1 add", mk(s[7:0], s[7:0] == 0, n[4], s[8], 1, 1, 1));
            end
        end
    endtask

    task automatic t_sub_sweep();
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                logic [7:0] d;
                d = 8'(b - a);
                apply(4'd1, 8'(a), 8'(b), 1'(a & 1));
                check("R2 sub", mk(d, d == 0, b[3:0] >= a[3:0], b >= a, 1, 1, 1));
            end
        end
        apply(4'd1, 8'h01, 8'h00, 1'b1);
        check("R2 borrow 0x00-0x01", mk(8'hFF, 0, 0, 0, 1, 1, 1));
    endtask

    task automatic t_coincide();
        apply(4'd0, 8'h80, 8'h80, 1'b0);
        check("R3 zero+carry", mk(8'h00, 1, 0, 1, 1, 1, 1));
        apply(4'd0, 8'h0F, 8'hF1, 1'b0);
        check("R3 zero+dc+carry", mk(8'h00, 1, 1, 1, 1, 1, 1));
        apply(4'd1, 8'h5A, 8'h5A, 1'b0);
        check("R3 equal subtract", mk(8'h00, 1, 1, 1, 1, 1, 1));
    endtask

    task automatic t_logic();
        apply(4'd2, 8'hF0, 8'h3C, 1'b1);
        check("R4 and", mk(8'h30, 0, 0, 0, 1, 0, 0));
        apply(4'd2, 8'h0F, 8'hF0, 1'b0);
        check("R4 and zero", mk(8'h00, 1, 0, 0, 1, 0, 0));
        apply(4'd3, 8'hF0, 8'h3C, 1'b0);
        check("R4 ior", mk(8'hFC, 0, 0, 0, 1, 0, 0));
        apply(4'd4, 8'hF0, 8'h3C, 1'b1);
        check("R4 xor", mk(8'hCC, 0, 0, 0, 1, 0, 0));
        apply(4'd4, 8'h66, 8'h66, 1'b0);
        check("R4 xor zero", mk(8'h00, 1, 0, 0, 1, 0, 0));
        apply(4'd5, 8'h00, 8'h12, 1'b0);
        check("R4 com", mk(8'hED, 0, 0, 0, 1, 0, 0));
        apply(4'd5, 8'hAB, 8'hFF, 1'b1);
        check("R4 com zero", mk(8'h00, 1, 0, 0, 1, 0, 0));
    endtask

    task automatic t_incdec();
        apply(4'd6, 8'h00, 8'hFF, 1'b1);
        check("R5 inc wrap", mk(8'h00, 1, 0, 0, 1, 0, 0));
        apply(4'd6, 8'h77, 8'h41, 1'b0);
        check("R5 inc", mk(8'h42, 0, 0, 0, 1, 0, 0));
        apply(4'd7, 8'h00, 8'h01, 1'b1);
        check("R5 dec to zero", mk(8'h00, 1, 0, 0, 1, 0, 0));
        apply(4'd7, 8'h10, 8'h00, 1'b0);
        check("R5 dec wrap", mk(8'hFF, 0, 0, 0, 1, 0, 0));
    endtask

    task automatic t_rotate();
        apply(4'd8, 8'h00, 8'h81, 1'b0);
        check("R6 rlc msb out", mk(8'h02, 0, 0, 1, 0, 0, 1));
        apply(4'd8, 8'hFF, 8'h40, 1'b1);
        check("R6 rlc carry in", mk(8'h81, 0, 0, 0, 0, 0, 1));
        apply(4'd9, 8'h00, 8'h01, 1'b1);
        check("R6 rrc both", mk(8'h80, 0, 0, 1, 0, 0, 1));
        apply(4'd9, 8'h00, 8'h01, 1'b0);
        check("R6 rrc to zero", mk(8'h00, 0, 0, 1, 0, 0, 1));
        apply(4'd9, 8'h00, 8'hA4, 1'b0);
        check("R6 rrc", mk(8'h52, 0, 0, 0, 0, 0, 1));
    endtask

    task automatic t_swap();
        apply(4'd10, 8'hFF, 8'hA5, 1'b1);
        check("R7 swap", mk(8'h5A, 0, 0, 0, 0, 0, 0));
        apply(4'd10, 8'h00, 8'h00, 1'b1);
        check("R7 swap zero no flag", mk(8'h00, 0, 0, 0, 0, 0, 0));
    endtask

    task automatic t_clr_pass();
        apply(4'd11, 8'h33, 8'h77, 1'b1);
        check("R8 clear", mk(8'h00, 1, 0, 0, 1, 0, 0));
        apply(4'd12, 8'h11, 8'h9C, 1'b1);
        check("R8 pass", mk(8'h9C, 0, 0, 0, 1, 0, 0));
        apply(4'd12, 8'hFF, 8'h00, 1'b0);
        check("R8 pass zero", mk(8'h00, 1, 0, 0, 1, 0, 0));
    endtask

    task automatic t_unused();
        for (int op = 13; op < 16; op++) begin
            apply(4'(op), 8'hFF, 8'hFF, 1'b1);
            check("R9 unused code", mk(8'h00, 0, 0, 0, 0, 0, 0));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_coincide();
        t_logic();
        t_incdec();
        t_rotate();
        t_swap();
        t_clr_pass();
        t_unused();
        t_add_sweep();
        t_sub_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule